// File: doc/BRIEF.md
# Accumulator Register-Operation Unit

This block carries out the register-reference class of instructions of a 16-bit accumulator machine. A word belongs to that class when its top four bits read 0111. The twelve bits below that each name one action. An action may change the 16-bit accumulator, change the 1-bit extend flag, ask the sequencer to skip the next instruction, or stop the machine.

The sequencer drives the instruction word, the current accumulator and the current extend flag, and pulses the execute strobe for one clock. On the next clock edge the unit registers the new accumulator and extend flag. On that same edge it raises a one-cycle skip request when the tested condition is true. The skip request tells the program counter to advance one extra step. The halt flag is sticky: once set, it stays set until reset, and the unit ignores every strobe while halted.

Only one action bit is expected per word. When a word sets several, the lowest-numbered set bit is the only one that acts.

Top module: `acc_regop_unit`

## Requirements
- R1: While rst_n is low at a clock edge, acc_out becomes 0, ext_out becomes 0, skip_req becomes 0 and halted becomes 0.
- R2: A strobed word whose bits 15..12 are not 0111, or whose bits 11..0 are all zero, loads acc_out and ext_out with acc_in and ext_in unchanged. It also leaves skip_req and halted at 0. All results appear one clock after the strobe.
- R3: Bit 11 clears the accumulator and keeps the extend flag. Bit 10 clears the extend flag and keeps the accumulator.
- R4: Bit 9 inverts every accumulator bit. Bit 8 inverts the extend flag.
- R5: Bit 7 rotates the 17-bit ring {extend, accumulator} right. The old extend flag enters accumulator bit 15, and old accumulator bit 0 becomes the extend flag.
- R6: Bit 6 rotates the ring left. Old accumulator bit 15 becomes the extend flag, and the old extend flag enters accumulator bit 0.
- R7: Bit 5 adds one to the accumulator modulo 2^16 and leaves the extend flag unchanged.
- R8: Bits 4, 3, 2 and 1 each raise skip_req for exactly one cycle when their condition holds. Bit 4 tests accumulator bit 15 = 0. Bit 3 tests accumulator bit 15 = 1. Bit 2 tests accumulator = 0. Bit 1 tests extend flag = 0. The accumulator and extend flag pass through unchanged.
- R9: Bit 0 sets halted. Halted stays at 1 until reset, and while it is 1 a strobe changes nothing and raises no skip.
- R10: When several of bits 11..0 are set, only the lowest-numbered set bit acts.
- R11: Without a strobe, acc_out and ext_out hold their values and skip_req is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exec | input | 1 | Execute strobe, one cycle per instruction |
| instr | input | 16 | Instruction word |
| acc_in | input | 16 | Current accumulator value |
| ext_in | input | 1 | Current extend flag |
| acc_out | output | 16 | Updated accumulator |
| ext_out | output | 1 | Updated extend flag |
| skip_req | output | 1 | One-cycle request for an extra program-counter step |
| halted | output | 1 | Sticky halt flag |

## Verification
Every result is registered one edge after the strobe, so a wrong decode or a wrong ring wiring shows at acc_out or ext_out in the very next cycle. A fault that flips a single ring bit shows as a result off by one bit position. A priority fault shows only on words with several bits set, so the vectors include such mixed words. A stuck halted or skip register shows as strobes that stop acting, or as a skip pulse that lasts longer than one cycle, within two cycles of the stimulus.

// File: rtl/acc_regop_pkg.sv
// Package: shared widths and action-bit positions for the register-operation unit.
// Assumes: instruction word = class field on top, action field below.
package acc_regop_pkg;
    localparam int WORD_W = 16;   // accumulator and instruction width
    localparam int ACT_W  = 12;   // action field width
    localparam int CLS_W  = WORD_W - ACT_W;

    // Action-bit positions within the action field (order defines priority).
    localparam int A_HALT   = 0;
    localparam int A_SKZE   = 1;
    localparam int A_SKZACC = 2;
    localparam int A_SKNEG  = 3;
    localparam int A_SKPOS  = 4;
    localparam int A_INC    = 5;
    localparam int A_ROTL   = 6;
    localparam int A_ROTR   = 7;
    localparam int A_INVE   = 8;
    localparam int A_INVACC = 9;
    localparam int A_CLRE   = 10;
    localparam int A_CLRACC = 11;

    // Class code marking a register-operation word.
    localparam logic [CLS_W-1:0] CLS_REGOP = {1'b0, {(CLS_W-1){1'b1}}};
endpackage

// File: rtl/acc_regop_decode.sv
// Module: class check plus lowest-bit-wins priority select of one action.
// Assumes: sel is all-zero for foreign words or an empty action field.
module acc_regop_decode
    import acc_regop_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = ACT_W
) (
    input  logic [W-1:0]  word,
    output logic          is_regop,
    output logic [AW-1:0] sel
);
    localparam int CW = W - AW;

    // Class detection on the upper field.
    always_comb begin
        is_regop = (word[W-1:AW] == CLS_REGOP[CW-1:0]);
    end

    // Priority: an action bit acts only if no lower bit is set.
    always_comb begin
        logic seen;
        seen = 1'b0;
        sel  = '0;
        for (int i = 0; i < AW; i++) begin
            sel[i] = is_regop & word[i] & ~seen;
            seen   = seen | word[i];
        end
    end
endmodule

// File: rtl/acc_regop_alu.sv
// Module: computes the next accumulator and extend flag from a one-hot action.
// Assumes: sel is one-hot or zero; zero means pass-through.
module acc_regop_alu
    import acc_regop_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = ACT_W
) (
    input  logic [AW-1:0] sel,
    input  logic [W-1:0]  acc,
    input  logic          ext,
    output logic [W-1:0]  acc_nx,
    output logic          ext_nx
);
    // Next-state selection over the {ext, acc} ring.
    always_comb begin
        acc_nx = acc;
        ext_nx = ext;
        if (sel[A_CLRACC]) acc_nx = '0;
        if (sel[A_CLRE])   ext_nx = 1'b0;
        if (sel[A_INVACC]) acc_nx = ~acc;
        if (sel[A_INVE])   ext_nx = ~ext;
        if (sel[A_ROTR]) begin
            acc_nx = {ext, acc[W-1:1]};
            ext_nx = acc[0];
        end
        if (sel[A_ROTL]) begin
            acc_nx = {acc[W-2:0], ext};
            ext_nx = acc[W-1];
        end
        if (sel[A_INC])    acc_nx = acc + {{(W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/acc_regop_skip.sv
// Module: evaluates the conditional-skip actions against current state.
// Assumes: sel is one-hot or zero; at most one condition is tested.
module acc_regop_skip
    import acc_regop_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = ACT_W
) (
    input  logic [AW-1:0] sel,
    input  logic [W-1:0]  acc,
    input  logic          ext,
    output logic          hit
);
    logic [3:0] cond;

    // Condition vector in the same order as the skip action bits.
    always_comb begin
        cond[0] = ~ext;
        cond[1] = (acc == '0);
        cond[2] = acc[W-1];
        cond[3] = ~acc[W-1];
    end

    // Hit when the selected skip action's condition is true.
    always_comb begin
        hit = |(sel[A_SKPOS:A_SKZE] & cond);
    end
endmodule

// File: rtl/acc_regop_unit.sv
// Module: register-operation execution unit with registered results.
// Assumes: exec is a one-cycle strobe; results appear one edge later.
module acc_regop_unit
    import acc_regop_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = ACT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] acc_in,
    input  logic         ext_in,
    output logic [W-1:0] acc_out,
    output logic         ext_out,
    output logic         skip_req,
    output logic         halted
);
    localparam int CW = W - AW;

    logic          is_regop;
    logic [AW-1:0] sel;
    logic [W-1:0]  acc_nx;
    logic          ext_nx;
    logic          skip_hit;

    acc_regop_decode #(.W(W), .AW(AW)) u_dec (
        .word(instr), .is_regop(is_regop), .sel(sel)
    );

    acc_regop_alu #(.W(W), .AW(AW)) u_alu (
        .sel(sel), .acc(acc_in), .ext(ext_in), .acc_nx(acc_nx), .ext_nx(ext_nx)
    );

    acc_regop_skip #(.W(W), .AW(AW)) u_skp (
        .sel(sel), .acc(acc_in), .ext(ext_in), .hit(skip_hit)
    );

    // Result, skip pulse and sticky halt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out  <= '0;
            ext_out  <= 1'b0;
            skip_req <= 1'b0;
            halted   <= 1'b0;
        end else if (exec && !halted) begin
            acc_out  <= acc_nx;
            ext_out  <= ext_nx;
            skip_req <= skip_hit;
            if (sel[A_HALT]) halted <= 1'b1;
        end else begin
            skip_req <= 1'b0;
        end
    end

    // Foreign class leaves state untouched and requests nothing.
    assert_foreign_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !halted && instr[W-1:AW] != CLS_REGOP[CW-1:0]) |=>
        (acc_out == $past(acc_in) && ext_out == $past(ext_in) && !skip_req && !halted));

    // Pure clear of accumulator.
    assert_clear_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !halted && instr == {CLS_REGOP[CW-1:0], AW'(1 << A_CLRACC)}) |=>
        (acc_out == '0 && ext_out == $past(ext_in)));

    // Pure increment wraps and keeps extend.
    assert_inc_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !halted && instr == {CLS_REGOP[CW-1:0], AW'(1 << A_INC)}) |=>
        (acc_out == W'($past(acc_in) + 1'b1) && ext_out == $past(ext_in)));

    // Skip pulse only follows a strobe.
    assert_skip_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> $past(exec));

    // Halt is sticky.
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // Halted state freezes results and suppresses skips.
    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(acc_out) && $stable(ext_out) && !skip_req));

    // Idle cycles hold results.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> ($stable(acc_out) && $stable(ext_out) && !skip_req));
endmodule

// File: tb/acc_regop_unit_tb_top.sv
// Bench: vector table walk plus directed reset, idle and halt tests.
module acc_regop_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] acc_in = '0;
    logic        ext_in = 1'b0;
    logic [15:0] acc_out;
    logic        ext_out;
    logic        skip_req;
    logic        halted;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    acc_regop_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exec(exec), .instr(instr),
        .acc_in(acc_in), .ext_in(ext_in), .acc_out(acc_out),
        .ext_out(ext_out), .skip_req(skip_req), .halted(halted)
    );

    // Fields: instr, acc, ext, exp_acc, exp_ext, exp_skip, req number.
    localparam int NV = 31;
    localparam logic [54:0] VEC [NV] = '{
        {16'h7800, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd3},  // R3
        {16'h7400, 16'h1234, 1'b1, 16'h1234, 1'b0, 1'b0, 4'd3},  // R3
        {16'h7200, 16'h00FF, 1'b0, 16'hFF00, 1'b0, 1'b0, 4'd4},  // R4
        {16'h7100, 16'h5555, 1'b0, 16'h5555, 1'b1, 1'b0, 4'd4},  // R4
        {16'h7100, 16'h5555, 1'b1, 16'h5555, 1'b0, 1'b0, 4'd4},  // R4
        {16'h7080, 16'h0003, 1'b1, 16'h8001, 1'b1, 1'b0, 4'd5},  // R5
        {16'h7080, 16'h8000, 1'b0, 16'h4000, 1'b0, 1'b0, 4'd5},  // R5
        {16'h7040, 16'h8001, 1'b0, 16'h0002, 1'b1, 1'b0, 4'd6},  // R6
        {16'h7040, 16'h4000, 1'b1, 16'h8001, 1'b0, 1'b0, 4'd6},  // R6
        {16'h7020, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd7},  // R7
        {16'h7020, 16'h0041, 1'b0, 16'h0042, 1'b0, 1'b0, 4'd7},  // R7
        {16'h7010, 16'h7FFF, 1'b0, 16'h7FFF, 1'b0, 1'b1, 4'd8},  // R8
        {16'h7010, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b0, 4'd8},  // R8
        {16'h7008, 16'h8000, 1'b1, 16'h8000, 1'b1, 1'b1, 4'd8},  // R8
        {16'h7008, 16'h0001, 1'b1, 16'h0001, 1'b1, 1'b0, 4'd8},  // R8
        {16'h7004, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1, 4'd8},  // R8
        {16'h7004, 16'h0100, 1'b0, 16'h0100, 1'b0, 1'b0, 4'd8},  // R8
        {16'h7002, 16'h1234, 1'b0, 16'h1234, 1'b0, 1'b1, 4'd8},  // R8
        {16'h7002, 16'h1234, 1'b1, 16'h1234, 1'b1, 1'b0, 4'd8},  // R8
        {16'h3800, 16'h1234, 1'b1, 16'h1234, 1'b1, 1'b0, 4'd2},  // R2
        {16'hF800, 16'hABCD, 1'b0, 16'hABCD, 1'b0, 1'b0, 4'd2},  // R2
        {16'hF001, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd2},  // R2
        {16'h7000, 16'h4321, 1'b1, 16'h4321, 1'b1, 1'b0, 4'd2},  // R2
        {16'h0FFF, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2
        {16'h7A00, 16'h1234, 1'b0, 16'hEDCB, 1'b0, 1'b0, 4'd10}, // R10
        {16'h7060, 16'h0001, 1'b0, 16'h0002, 1'b0, 1'b0, 4'd10}, // R10
        {16'h7C10, 16'h1234, 1'b1, 16'h1234, 1'b1, 1'b1, 4'd10}, // R10
        {16'h70C0, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd10}, // R10
        {16'h7820, 16'h00FF, 1'b1, 16'h0100, 1'b1, 1'b0, 4'd10}, // R10
        {16'h7300, 16'h0F0F, 1'b0, 16'h0F0F, 1'b1, 1'b0, 4'd10}, // R10
        {16'h7022, 16'h0007, 1'b0, 16'h0007, 1'b0, 1'b1, 4'd10}  // R10
    };

    // One compare with counting and a FAIL line on mismatch.
    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Strobe one word for one cycle; outputs are read at the following negedge.
    task automatic strobe(input logic [15:0] w, input logic [15:0] a, input logic e);
        instr = w; acc_in = a; ext_in = e; exec = 1'b1;
        @(negedge clk);
        exec = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "acc_out", acc_out, 16'h0000);
        chk("R1", "ext_out", {15'd0, ext_out}, 16'd0);
        chk("R1", "skip_req", {15'd0, skip_req}, 16'd0);
        chk("R1", "halted", {15'd0, halted}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            string r;
            r = $sformatf("R%0d", VEC[i][3:0]);
            strobe(VEC[i][54:39], VEC[i][38:23], VEC[i][22]);
            chk(r, "acc_out", acc_out, VEC[i][21:6]);
            chk(r, "ext_out", {15'd0, ext_out}, {15'd0, VEC[i][5]});
            chk(r, "skip_req", {15'd0, skip_req}, {15'd0, VEC[i][4]});
            chk(r, "halted", {15'd0, halted}, 16'd0);
        end

        // R8: skip lasts one cycle only.
        strobe(16'h7004, 16'h0000, 1'b0);
        chk("R8", "skip_req first", {15'd0, skip_req}, 16'd1);
        @(negedge clk);
        chk("R8", "skip_req second", {15'd0, skip_req}, 16'd0);

        // R11: idle hold with changing inputs.
        strobe(16'h7200, 16'h0F0F, 1'b1);
        instr = 16'h7800; acc_in = 16'hAAAA; ext_in = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R11", "acc_out hold", acc_out, 16'hF0F0);
        chk("R11", "ext_out hold", {15'd0, ext_out}, 16'd1);
        chk("R11", "skip_req idle", {15'd0, skip_req}, 16'd0);

        // R9, R10: halt wins over skip in the same word.
        strobe(16'h7003, 16'h2222, 1'b0);
        chk("R9", "halted set", {15'd0, halted}, 16'd1);
        chk("R10", "skip suppressed by halt", {15'd0, skip_req}, 16'd0);
        chk("R9", "acc_out on halt", acc_out, 16'h2222);

        // R9: strobes ignored while halted.
        strobe(16'h7800, 16'h5555, 1'b1);
        chk("R9", "acc_out frozen", acc_out, 16'h2222);
        chk("R9", "ext_out frozen", {15'd0, ext_out}, 16'd0);
        strobe(16'h7004, 16'h0000, 1'b0);
        chk("R9", "no skip when halted", {15'd0, skip_req}, 16'd0);
        chk("R9", "halted sticky", {15'd0, halted}, 16'd1);

        // R1: reset clears halt and results.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "halted after reset", {15'd0, halted}, 16'd0);
        chk("R1", "acc_out after reset", acc_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: unit works again after reset.
        strobe(16'h7020, 16'h0010, 1'b0);
        chk("R9", "acc_out after recovery", acc_out, 16'h0011);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule